// File: doc/BRIEF.md
# Multiplexed Address/Data Host Bus Slave

This block sits between an external host and the register file of a two-channel serial controller. The host uses one shared 8-bit bus for both address and data. An active-low latch strobe divides each transaction into two phases. While the strobe is low, the bus carries an address byte, and the block stores it. While the strobe is high, the bus carries data. Separate active-low read and write strobes then move one byte between the host and the register that was addressed.

All host strobes and the bus are sampled against a fast system clock through two-flop synchronizers. Edges are detected on the synchronized copies.

- A write commits when its strobe rises. The block then emits a one-cycle commit pulse for the addressed channel, together with the captured byte.
- A read starts when its strobe falls. The block then drives the addressed channel's register byte back to the host under an output enable. The enable is released when the read strobe returns high.

The register storage belongs to each channel. Each channel presents the byte for the current register index on its own read-data input.

Top module: `hbus_mux_if`

## Requirements
- R1: After reset, `bus_oe`, `wr_pulse_a` and `wr_pulse_b` are 0, and `reg_idx`, `chan_sel`, `wr_data` and `bus_out` are 0.
- R2: While `latch_n` is low, the bus value is captured as the address. Bit 3 selects the channel (0 = A, 1 = B) and appears on `chan_sel`. Bits 2:0 appear on `reg_idx`. Bits 7:4 have no effect. The outputs update on the third rising clock edge after the bus and `latch_n` are applied.
- R3: While `latch_n` is high, `reg_idx` and `chan_sel` keep their value, whatever the bus carries.
- R4: A falling `rd_n` during the data phase raises `bus_oe` on the third clock edge. On that same edge, `bus_out` takes `chan_a_rdata` when `chan_sel` is 0, or `chan_b_rdata` when `chan_sel` is 1. `bus_out` then stays stable while `bus_oe` stays high.
- R5: When `rd_n` returns high, `bus_oe` falls on the third clock edge.
- R6: A rising `wr_n` during the data phase produces exactly one single-cycle pulse, on the third clock edge. The pulse appears on `wr_pulse_a` when `chan_sel` is 0, or on `wr_pulse_b` when `chan_sel` is 1. `wr_data` carries the bus byte that was present at the rising edge.
- R7: Read or write strobe edges that occur while `latch_n` is low produce no write pulse and never assert `bus_oe`.
- R8: `wr_pulse_a` and `wr_pulse_b` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Shared address/data bus, as seen by the block |
| latch_n | input | 1 | Address-phase strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| chan_a_rdata | input | 8 | Channel A byte for the current `reg_idx` |
| chan_b_rdata | input | 8 | Channel B byte for the current `reg_idx` |
| bus_out | output | 8 | Read data driven towards the host |
| bus_oe | output | 1 | Output enable for `bus_out` |
| reg_idx | output | 3 | Latched register index |
| chan_sel | output | 1 | Latched channel select (0 = A, 1 = B) |
| wr_data | output | 8 | Byte committed by a write |
| wr_pulse_a | output | 1 | One-cycle write commit for channel A |
| wr_pulse_b | output | 1 | One-cycle write commit for channel B |

## Verification
Every result of this block arrives three rising clock edges after the host stimulus that causes it:

1. two synchronizer stages;
2. one registered output behind the edge detector.

This applies to the address outputs, the read enable and its data, the release of the enable, and the write pulse. The bench changes inputs on falling clock edges and samples outputs on falling edges. It reads the address and read results four falling edges after the stimulus, once the third rising edge has passed. It counts write pulses over a window of six cycles, so a pulse that is missing, doubled or sent to the wrong channel is caught regardless of its exact cycle.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int DATA_W    = 8;
  localparam int IDX_W     = 3;
  localparam int CHAN_BIT  = 3;
  localparam int NUM_CHAN  = 2;
  localparam int SYNC_DEPTH = 2;

  function automatic logic [IDX_W-1:0] addr_to_idx(input logic [DATA_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic addr_to_chan(input logic [DATA_W-1:0] a);
    return a[CHAN_BIT];
  endfunction

  function automatic logic [NUM_CHAN-1:0] chan_onehot(input logic c);
    logic [NUM_CHAN-1:0] r;
    r = '0;
    r[c] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbus_edge.sv
module hbus_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch
  import hbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_phase,
  input  logic [DATA_W-1:0] bus_s,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              chan_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_idx  <= '0;
      chan_sel <= 1'b0;
    end else if (addr_phase) begin
      reg_idx  <= addr_to_idx(bus_s);
      chan_sel <= addr_to_chan(bus_s);
    end
  end
endmodule

// File: rtl/hbus_rd_path.sv
module hbus_rd_path
  import hbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_phase,
  input  logic              rd_start,
  input  logic              rd_idle,
  input  logic              chan_sel,
  input  logic [DATA_W-1:0] byte_a,
  input  logic [DATA_W-1:0] byte_b,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_oe  <= 1'b0;
      bus_out <= '0;
    end else if (!data_phase || rd_idle) begin
      bus_oe <= 1'b0;
    end else if (rd_start) begin
      bus_oe  <= 1'b1;
      bus_out <= chan_sel ? byte_b : byte_a;
    end
  end
endmodule

// File: rtl/hbus_wr_path.sv
module hbus_wr_path
  import hbus_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_phase,
  input  logic                wr_commit,
  input  logic                chan_sel,
  input  logic [DATA_W-1:0]   bus_s,
  output logic [NUM_CHAN-1:0] wr_pulse,
  output logic [DATA_W-1:0]   wr_data
);
  logic fire;
  assign fire = wr_commit & data_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pulse <= '0;
      wr_data  <= '0;
    end else begin
      wr_pulse <= fire ? chan_onehot(chan_sel) : '0;
      if (fire) wr_data <= bus_s;
    end
  end
endmodule

// File: rtl/hbus_mux_if.sv
module hbus_mux_if
  import hbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              latch_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] chan_a_rdata,
  input  logic [DATA_W-1:0] chan_b_rdata,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              chan_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_pulse_a,
  output logic              wr_pulse_b
);
  localparam int STROBES = 3;

  logic [STROBES-1:0] strobe_s;
  logic [DATA_W-1:0]  bus_s;
  logic latch_sync, rd_sync, wr_sync;
  logic rd_rise, rd_fall, wr_rise, wr_fall;
  logic [NUM_CHAN-1:0] pulses;

  hbus_sync #(.W(STROBES), .STAGES(SYNC_DEPTH), .RST_VAL({STROBES{1'b1}})) strobe_sync_i (
    .clk(clk), .rst_n(rst_n), .d({latch_n, rd_n, wr_n}), .q(strobe_s));

  hbus_sync #(.W(DATA_W), .STAGES(SYNC_DEPTH), .RST_VAL('0)) bus_sync_i (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s));

  assign latch_sync = strobe_s[2];
  assign rd_sync    = strobe_s[1];
  assign wr_sync    = strobe_s[0];

  hbus_edge rd_edge_i (.clk(clk), .rst_n(rst_n), .lvl(rd_sync), .rise(rd_rise), .fall(rd_fall));
  hbus_edge wr_edge_i (.clk(clk), .rst_n(rst_n), .lvl(wr_sync), .rise(wr_rise), .fall(wr_fall));

  hbus_addr_latch addr_i (
    .clk(clk), .rst_n(rst_n), .addr_phase(~latch_sync), .bus_s(bus_s),
    .reg_idx(reg_idx), .chan_sel(chan_sel));

  hbus_rd_path rd_i (
    .clk(clk), .rst_n(rst_n), .data_phase(latch_sync), .rd_start(rd_fall),
    .rd_idle(rd_sync), .chan_sel(chan_sel), .byte_a(chan_a_rdata),
    .byte_b(chan_b_rdata), .bus_out(bus_out), .bus_oe(bus_oe));

  hbus_wr_path wr_i (
    .clk(clk), .rst_n(rst_n), .data_phase(latch_sync), .wr_commit(wr_rise),
    .chan_sel(chan_sel), .bus_s(bus_s), .wr_pulse(pulses), .wr_data(wr_data));

  assign wr_pulse_a = pulses[0];
  assign wr_pulse_b = pulses[1];

  logic unused_ok;
  assign unused_ok = rd_rise ^ wr_fall;
endmodule

// File: rtl/hbus_mux_if_chk.sv
module hbus_mux_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_oe,
  input logic [7:0] bus_out,
  input logic [2:0] reg_idx,
  input logic       chan_sel,
  input logic       wr_pulse_a,
  input logic       wr_pulse_b,
  input logic       latch_sync,
  input logic       rd_sync
);
  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_pulse_a, wr_pulse_b}));

  // R6
  pulse_a_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_a |=> !wr_pulse_a);

  // R6
  pulse_b_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_b |=> !wr_pulse_b);

  // R7
  oe_data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(latch_sync));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(latch_sync) |-> $stable({reg_idx, chan_sel}));

  // R4
  rdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_out));

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_sync) |-> !bus_oe);
endmodule

bind hbus_mux_if hbus_mux_if_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_oe(bus_oe), .bus_out(bus_out),
  .reg_idx(reg_idx), .chan_sel(chan_sel), .wr_pulse_a(wr_pulse_a),
  .wr_pulse_b(wr_pulse_b), .latch_sync(latch_sync), .rd_sync(rd_sync));

// File: tb/hbus_mux_if_tb_top.sv
module hbus_mux_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic latch_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] chan_a_rdata, chan_b_rdata, bus_out, wr_data;
  logic bus_oe, chan_sel, wr_pulse_a, wr_pulse_b;
  logic [2:0] reg_idx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign chan_a_rdata = {4'hA, 1'b0, reg_idx};
  assign chan_b_rdata = {4'h5, 1'b0, reg_idx};

  hbus_mux_if dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .latch_n(latch_n), .rd_n(rd_n),
    .wr_n(wr_n), .chan_a_rdata(chan_a_rdata), .chan_b_rdata(chan_b_rdata),
    .bus_out(bus_out), .bus_oe(bus_oe), .reg_idx(reg_idx), .chan_sel(chan_sel),
    .wr_data(wr_data), .wr_pulse_a(wr_pulse_a), .wr_pulse_b(wr_pulse_b));

  // {address byte, write byte}
  localparam logic [15:0] VEC [6] = '{
    16'h0_3_5A, 16'h0_8_C3, 16'hF_7_01, 16'hA_F_FF, 16'h0_0_00, 16'h5_9_7E
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [7:0] a);
    bus_in = a; latch_n = 1'b0;
    cyc(4);
    latch_n = 1'b1;
    cyc(3);
  endtask

  task automatic do_write(input logic [7:0] d, output int na, output int nb, output logic [7:0] wd);
    na = 0; nb = 0; wd = 8'h00;
    bus_in = d; wr_n = 1'b0;
    cyc(3);
    wr_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (wr_pulse_a) begin na++; wd = wr_data; end
      if (wr_pulse_b) begin nb++; wd = wr_data; end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int na, nb;
    logic [7:0] wd, a, d, exp_rd;
    cyc(3);
    // R1 reset state
    chk("R1 oe", {31'b0, bus_oe}, 0);
    chk("R1 pulses", {30'b0, wr_pulse_a, wr_pulse_b}, 0);
    chk("R1 addr", {28'b0, chan_sel, reg_idx}, 0);
    chk("R1 data", {16'b0, wr_data, bus_out}, 0);
    rst_n = 1'b1;
    cyc(2);

    for (int v = 0; v < 6; v++) begin
      a = VEC[v][15:8]; d = VEC[v][7:0];
      addr_phase(a);
      // R2 channel from bit 3, index from bits 2:0
      chk("R2 idx", {29'b0, reg_idx}, {29'b0, a[2:0]});
      chk("R2 chan", {31'b0, chan_sel}, {31'b0, a[3]});
      // R3 bus changes in data phase are ignored
      bus_in = ~a; cyc(5);
      chk("R3 hold", {28'b0, chan_sel, reg_idx}, {28'b0, a[3:0]});
      // R6 write commit
      do_write(d, na, nb, wd);
      chk("R6 count a", na, a[3] ? 0 : 1);
      chk("R6 count b", nb, a[3] ? 1 : 0);
      chk("R6 data", {24'b0, wd}, {24'b0, d});
      // R4 read
      exp_rd = a[3] ? {4'h5, 1'b0, a[2:0]} : {4'hA, 1'b0, a[2:0]};
      rd_n = 1'b0;
      cyc(2);
      chk("R4 oe not early", {31'b0, bus_oe}, 0);
      cyc(2);
      chk("R4 oe", {31'b0, bus_oe}, 1);
      chk("R4 data", {24'b0, bus_out}, {24'b0, exp_rd});
      // R5 release
      rd_n = 1'b1;
      cyc(2);
      chk("R5 oe held", {31'b0, bus_oe}, 1);
      cyc(2);
      chk("R5 oe off", {31'b0, bus_oe}, 0);
    end

    // R7 strobes during address phase are ignored
    bus_in = 8'h0B; latch_n = 1'b0;
    cyc(3);
    rd_n = 1'b0; wr_n = 1'b0;
    cyc(3);
    na = 0; nb = 0;
    wr_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (wr_pulse_a) na++;
      if (wr_pulse_b) nb++;
      if (bus_oe) na += 100;
    end
    chk("R7 no pulse or oe", na + nb, 0);
    latch_n = 1'b1;
    cyc(6);
    chk("R7 oe stays low", {31'b0, bus_oe}, 0);
    rd_n = 1'b1;
    cyc(4);
    chk("R2 idx after R7", {28'b0, chan_sel, reg_idx}, 32'hB);

    // R8 back-to-back writes to A then B never overlap
    addr_phase(8'h02);
    do_write(8'h11, na, nb, wd);
    chk("R8 a only", {na[15:0], nb[15:0]}, 32'h0001_0000);
    addr_phase(8'h0A);
    do_write(8'h22, na, nb, wd);
    chk("R8 b only", {na[15:0], nb[15:0]}, 32'h0000_0001);
    chk("R6 data b", {24'b0, wd}, 32'h22);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule